// File: doc/BRIEF.md
# MEI snoop response controller

This block keeps a set-associative data cache coherent with other masters on a shared bus. The cache lines use three states: Modified (dirty, sole copy), Exclusive (clean, sole copy) and Invalid. The controller holds the tag and state array for the cache. It watches every bus transfer start, and it reacts only to transfers that carry the global attribute in the same clock. For a reacting transfer it looks the line address up in all ways of the indexed set, then decides whether to tell the other master to retry. It also decides whether to demand a write-back (push) of dirty data and what state the line takes next.

The cache side loads lines through a fill port. It reports a pending cast-out by giving the address of the victim line. It acknowledges a finished push with a done pulse. The controller reports every state change it makes through an update port, so that a mirror of the tags can follow along. When a snoop lands on a line whose cast-out is still waiting, the controller retries the snoop and raises an urgency flag. The cast-out can then take the bus ahead of the line fill that replaces it.

Top module: `mei_snoop_ctrl`

## Requirements
- R1: A transfer is snooped only when `bus_start` and `bus_glob` are both high in the same clock. A start without global, a global without start, or the two in consecutive clocks produces no retry, no update and no change of line state.
- R2: The response to a snoop appears in the second clock after the clock that qualified it. `snp_retry` is a pulse one clock long. `upd_valid` and its fields appear in that same clock.
- R3: A qualified snoop whose line matches no valid way of its set gives no retry and no update.
- R4: A hit on an Exclusive line (state code 01) from a read (transfer code 00) gives no retry and no update. A hit from read-with-intent-to-modify (01), write (10) or kill (11) moves the line to Invalid (00) and reports it, without retry.
- R5: A hit on a Modified line (state code 10) retries the snoop and raises `push_req`. `push_addr` carries the line address with the offset bits at zero. The line moves to Exclusive for a read (00) and to Invalid for any other transfer code, and the update is reported.
- R6: While a push is outstanding, a qualified snoop to the pushed line is retried with no update, even when `co_pend` names the same line. A hit on another Modified line is retried with no state change. `push_req` and `push_addr` hold until `push_done` is seen.
- R7: When `co_pend` is high and a qualified snoop's line equals the line of `co_addr`, the snoop is retried with no state change. `co_urgent` rises in the retry clock and stays high until the clock after `co_pend` falls.
- R8: A fill writes the tag and state of the given way in the set that the fill address selects, and later snoops see that line.
- R9: `upd_set` gives the set index bits of the snooped address and `upd_way` gives the way that matched.
- R10: Reset leaves every line Invalid and `snp_retry`, `push_req`, `co_urgent` and `upd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | Transfer start from another master |
| bus_glob | input | 1 | Global attribute of the transfer |
| bus_addr | input | ADDR_W | Transfer address |
| bus_kind | input | 2 | Transfer code: 00 read, 01 read-intent-modify, 10 write, 11 kill |
| fill_en | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_way | input | log2(WAYS) | Way to install into |
| fill_state | input | 2 | State to install: 00 I, 01 E, 10 M |
| co_pend | input | 1 | A cast-out is waiting for the bus |
| co_addr | input | ADDR_W | Address of the waiting cast-out |
| push_done | input | 1 | The outstanding push has completed |
| snp_retry | output | 1 | Retry pulse to the snooped master |
| push_req | output | 1 | Push of a dirty line is outstanding |
| push_addr | output | ADDR_W | Line address of the push, offset zero |
| co_urgent | output | 1 | Waiting cast-out must go ahead of the fill |
| upd_valid | output | 1 | A snoop changed a line state |
| upd_set | output | log2(SETS) | Set of the changed line |
| upd_way | output | log2(WAYS) | Way of the changed line |
| upd_state | output | 2 | New state of the changed line |

## Verification
Two functions can land in the same lookup clock: the outstanding-push match and the pending cast-out match. Both test the snooped line against a held address. The bench sets `co_pend` on the very line that is still being pushed and snoops that line. It expects the push match to win: a retry with `co_urgent` still low. It then repeats the snoop once the push has completed, and there the cast-out rule must take over. Random runs also mix cast-out addresses, outstanding pushes and tag hits on a small address pool, and a bench model judges which rule applies.

// File: rtl/mei_snoop_pkg.sv
package mei_snoop_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_E = 2'b01,
      ST_M = 2'b10
   } mei_state_e;

   typedef enum logic [1:0] {
      TT_READ  = 2'b00,
      TT_RWITM = 2'b01,
      TT_WRITE = 2'b10,
      TT_KILL  = 2'b11
   } xfer_kind_e;

   typedef struct packed {
      logic       retry;
      logic       push;
      logic       boost;
      logic       upd;
      mei_state_e nxt;
   } snoop_verdict_t;

endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store
   import mei_snoop_pkg::*;
#(
   parameter int LINE_W = 27,
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int TAG_W = LINE_W - SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [LINE_W-1:0] fill_line,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [1:0]        fill_state,
   input  logic              upd_en,
   input  logic [SET_W-1:0]  upd_set,
   input  logic [WAY_W-1:0]  upd_way,
   input  mei_state_e        upd_state,
   input  logic [LINE_W-1:0] look_line,
   output logic              hit,
   output logic [WAY_W-1:0]  hit_way,
   output mei_state_e        hit_state
);

   logic [SET_W-1:0] fill_set, look_set;
   logic [TAG_W-1:0] fill_tag, look_tag;

   assign fill_set = fill_line[SET_W-1:0];
   assign fill_tag = fill_line[LINE_W-1:SET_W];
   assign look_set = look_line[SET_W-1:0];
   assign look_tag = look_line[LINE_W-1:SET_W];

   logic [WAYS-1:0] way_hit;
   mei_state_e      way_st [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      mei_state_e       st_q  [SETS];
      logic             fill_here, upd_here;

      assign fill_here = fill_en && (fill_way == WAY_W'(w));
      assign upd_here  = upd_en && (upd_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) st_q[s] <= ST_I;
         end else begin
            if (upd_here) st_q[upd_set] <= upd_state;
            if (fill_here) st_q[fill_set] <= mei_state_e'(fill_state);
         end
      end

      always_ff @(posedge clk) begin
         if (fill_here) tag_q[fill_set] <= fill_tag;
      end

      assign way_st[w]  = st_q[look_set];
      assign way_hit[w] = (st_q[look_set] != ST_I) && (tag_q[look_set] == look_tag);
   end

   always_comb begin
      hit_way   = '0;
      hit_state = ST_I;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) begin
            hit_way   = WAY_W'(w);
            hit_state = way_st[w];
         end
      end
   end

   assign hit = |way_hit;

endmodule

// File: rtl/mei_snoop_decide.sv
module mei_snoop_decide
   import mei_snoop_pkg::*;
(
   input  logic           vld,
   input  xfer_kind_e     kind,
   input  logic           hit,
   input  mei_state_e     hit_state,
   input  logic           push_busy,
   input  logic           push_match,
   input  logic           co_pend,
   input  logic           co_match,
   output snoop_verdict_t verdict
);

   logic modifying;
   assign modifying = (kind != TT_READ);

   always_comb begin
      verdict     = '0;
      verdict.nxt = hit_state;
      if (vld) begin
         if (push_busy && push_match) begin
            verdict.retry = 1'b1;
         end else if (co_pend && co_match) begin
            verdict.retry = 1'b1;
            verdict.boost = 1'b1;
         end else if (hit) begin
            case (hit_state)
               ST_M: begin
                  verdict.retry = 1'b1;
                  if (!push_busy) begin
                     verdict.push = 1'b1;
                     verdict.upd  = 1'b1;
                     verdict.nxt  = modifying ? ST_I : ST_E;
                  end
               end
               ST_E: begin
                  if (modifying) begin
                     verdict.upd = 1'b1;
                     verdict.nxt = ST_I;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/mei_snoop_ctrl.sv
module mei_snoop_ctrl
   import mei_snoop_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_glob,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_kind,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [1:0]        fill_state,
   input  logic              co_pend,
   input  logic [ADDR_W-1:0] co_addr,
   input  logic              push_done,
   output logic              snp_retry,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_addr,
   output logic              co_urgent,
   output logic              upd_valid,
   output logic [SET_W-1:0]  upd_set,
   output logic [WAY_W-1:0]  upd_way,
   output logic [1:0]        upd_state
);

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (OFF_W < 1 || LINE_W <= SET_W) begin : g_bad_addr
      $error("address split leaves no offset or no tag");
   end

   logic unused_low;
   assign unused_low = ^{bus_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], co_addr[OFF_W-1:0]};

   // stage 1: capture of a qualified transfer
   logic              s1_vld;
   logic [LINE_W-1:0] s1_line;
   xfer_kind_e        s1_kind;
   logic              qual;

   assign qual = bus_start && bus_glob;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_line <= '0;
         s1_kind <= TT_READ;
      end else begin
         s1_vld <= qual;
         if (qual) begin
            s1_line <= bus_addr[ADDR_W-1:OFF_W];
            s1_kind <= xfer_kind_e'(bus_kind);
         end
      end
   end

   // lookup
   logic              hit;
   logic [WAY_W-1:0]  hit_way;
   mei_state_e        hit_state;
   snoop_verdict_t    verdict;
   logic              push_busy_q;
   logic [LINE_W-1:0] push_line_q;
   logic              push_match, co_match;

   assign push_match = (s1_line == push_line_q);
   assign co_match   = (s1_line == co_addr[ADDR_W-1:OFF_W]);

   mei_tag_store #(
      .LINE_W (LINE_W),
      .SETS   (SETS),
      .WAYS   (WAYS)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_en),
      .fill_line  (fill_addr[ADDR_W-1:OFF_W]),
      .fill_way   (fill_way),
      .fill_state (fill_state),
      .upd_en     (verdict.upd),
      .upd_set    (s1_line[SET_W-1:0]),
      .upd_way    (hit_way),
      .upd_state  (verdict.nxt),
      .look_line  (s1_line),
      .hit        (hit),
      .hit_way    (hit_way),
      .hit_state  (hit_state)
   );

   mei_snoop_decide u_decide (
      .vld        (s1_vld),
      .kind       (s1_kind),
      .hit        (hit),
      .hit_state  (hit_state),
      .push_busy  (push_busy_q),
      .push_match (push_match),
      .co_pend    (co_pend),
      .co_match   (co_match),
      .verdict    (verdict)
   );

   // stage 2: response registers
   logic             retry_q, upd_v_q, hipri_q;
   logic [SET_W-1:0] upd_set_q;
   logic [WAY_W-1:0] upd_way_q;
   mei_state_e       upd_st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retry_q     <= 1'b0;
         upd_v_q     <= 1'b0;
         upd_set_q   <= '0;
         upd_way_q   <= '0;
         upd_st_q    <= ST_I;
         push_busy_q <= 1'b0;
         push_line_q <= '0;
         hipri_q     <= 1'b0;
      end else begin
         retry_q <= verdict.retry;
         upd_v_q <= verdict.upd;
         if (verdict.upd) begin
            upd_set_q <= s1_line[SET_W-1:0];
            upd_way_q <= hit_way;
            upd_st_q  <= verdict.nxt;
         end
         if (verdict.push) begin
            push_busy_q <= 1'b1;
            push_line_q <= s1_line;
         end else if (push_done) begin
            push_busy_q <= 1'b0;
         end
         if (!co_pend) hipri_q <= 1'b0;
         else if (verdict.boost) hipri_q <= 1'b1;
      end
   end

   assign snp_retry = retry_q;
   assign push_req  = push_busy_q;
   assign push_addr = {push_line_q, {OFF_W{1'b0}}};
   assign co_urgent = hipri_q;
   assign upd_valid = upd_v_q;
   assign upd_set   = upd_set_q;
   assign upd_way   = upd_way_q;
   assign upd_state = upd_st_q;

endmodule

// File: rtl/mei_snoop_chk.sv
module mei_snoop_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_start,
   input logic              bus_glob,
   input logic              co_pend,
   input logic              push_done,
   input logic              snp_retry,
   input logic              push_req,
   input logic [ADDR_W-1:0] push_addr,
   input logic              co_urgent,
   input logic              upd_valid,
   input logic [1:0]        upd_state
);

   AST_RETRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      snp_retry |-> $past(bus_start && bus_glob, 2)); // R2

   AST_UPD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $past(bus_start && bus_glob, 2)); // R1

   AST_UPD_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_state != 2'b10)); // R4

   AST_PUSH_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_req) |-> snp_retry); // R5

   AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !push_done) |=> (push_req && $stable(push_addr))); // R6

   AST_URGENT_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(co_urgent) |-> snp_retry); // R7

   AST_URGENT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !co_pend |=> !co_urgent); // R7

endmodule

bind mei_snoop_ctrl mei_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_start (bus_start),
   .bus_glob  (bus_glob),
   .co_pend   (co_pend),
   .push_done (push_done),
   .snp_retry (snp_retry),
   .push_req  (push_req),
   .push_addr (push_addr),
   .co_urgent (co_urgent),
   .upd_valid (upd_valid),
   .upd_state (upd_state)
);

// File: tb/sim_mei_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mei_snoop_ctrl;

   localparam int AW = 32;
   localparam int OW = 5;
   localparam int NS = 16;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_start = 1'b0, bus_glob = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_kind = '0;
   logic          fill_en = 1'b0;
   logic [AW-1:0] fill_addr = '0;
   logic [1:0]    fill_way = '0;
   logic [1:0]    fill_state = '0;
   logic          co_pend = 1'b0;
   logic [AW-1:0] co_addr = '0;
   logic          push_done = 1'b0;
   logic          snp_retry, push_req, co_urgent, upd_valid;
   logic [AW-1:0] push_addr;
   logic [3:0]    upd_set;
   logic [1:0]    upd_way, upd_state;

   always #10 clk = ~clk;

   mei_snoop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_glob(bus_glob),
      .bus_addr(bus_addr), .bus_kind(bus_kind), .fill_en(fill_en), .fill_addr(fill_addr),
      .fill_way(fill_way), .fill_state(fill_state), .co_pend(co_pend), .co_addr(co_addr),
      .push_done(push_done), .snp_retry(snp_retry), .push_req(push_req), .push_addr(push_addr),
      .co_urgent(co_urgent), .upd_valid(upd_valid), .upd_set(upd_set), .upd_way(upd_way),
      .upd_state(upd_state)
   );

   int  checks = 0, errors = 0;
   bit  finished = 0;

   // bench model
   int           m_tag [NS][NW];
   int           m_st  [NS][NW];
   bit           m_busy = 0;
   logic [26:0]  m_pline = '0;
   bit           m_co_pend = 0;
   logic [26:0]  m_co_line = '0;
   bit           m_urg = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
      return (32'(tag) << 9) | (32'(set) << 5) | 32'(off);
   endfunction

   task automatic fill(input int set, input int way, input int tag, input int st);
      fill_en = 1'b1; fill_addr = mk_addr(tag, set, 0);
      fill_way = 2'(way); fill_state = 2'(st);
      @(posedge clk); @(negedge clk);
      fill_en = 1'b0;
      m_tag[set][way] = tag; m_st[set][way] = st;
   endtask

   task automatic finish_push();
      push_done = 1'b1;
      @(posedge clk); @(negedge clk);
      push_done = 1'b0;
      m_busy = 0;
      chk("R6", "push_req after done", longint'(push_req), 0);
   endtask

   task automatic set_co(input bit p, input logic [31:0] a);
      co_pend = 1'b0;
      @(posedge clk); @(negedge clk);
      m_urg = 0;
      chk("R7", "co_urgent after co_pend low", longint'(co_urgent), 0);
      co_pend = p; co_addr = a;
      m_co_pend = p; m_co_line = a[31:5];
   endtask

   // mode 0 qualified, 1 start only, 2 global only, 3 global then start
   task automatic snoop(input int mode, input logic [31:0] a, input int k, input string note);
      bit e_retry = 0, e_upd = 0;
      int e_set = 0, e_way = 0, e_st = 0, hw = -1;
      string why = "R1";
      int set = int'(a[8:5]);
      int tag = int'(a[31:9]);
      logic [26:0] line = a[31:5];
      if (mode == 0) begin
         why = "R3";
         if (m_busy && line == m_pline) begin
            e_retry = 1; why = "R6";
         end else if (m_co_pend && line == m_co_line) begin
            e_retry = 1; m_urg = 1; why = "R7";
         end else begin
            for (int w = 0; w < NW; w++)
               if (hw < 0 && m_st[set][w] != 0 && m_tag[set][w] == tag) hw = w;
            if (hw >= 0 && m_st[set][hw] == 2) begin
               e_retry = 1;
               if (m_busy) why = "R6";
               else begin
                  why = "R5"; e_upd = 1; e_st = (k == 0) ? 1 : 0;
                  m_busy = 1; m_pline = line;
               end
            end else if (hw >= 0 && m_st[set][hw] == 1) begin
               why = "R4";
               if (k != 0) begin e_upd = 1; e_st = 0; end
            end
            if (e_upd) begin m_st[set][hw] = e_st; e_set = set; e_way = hw; end
         end
      end
      why = {why, note};
      bus_addr = a; bus_kind = 2'(k);
      bus_start = (mode == 0 || mode == 1);
      bus_glob  = (mode != 1);
      @(posedge clk); @(negedge clk);
      chk("R2", "retry one clock after start", longint'(snp_retry), 0);
      bus_start = (mode == 3); bus_glob = 1'b0;
      @(posedge clk); @(negedge clk);
      bus_start = 1'b0;
      chk(why, "retry", longint'(snp_retry), longint'(e_retry));
      chk(why, "upd_valid", longint'(upd_valid), longint'(e_upd));
      if (e_upd) begin
         chk("R9", "upd_set", longint'(upd_set), longint'(e_set));
         chk("R9", "upd_way", longint'(upd_way), longint'(e_way));
         chk(why, "upd_state", longint'(upd_state), longint'(e_st));
      end
      chk(why, "push_req", longint'(push_req), longint'(m_busy));
      if (m_busy) chk("R5", "push_addr", longint'(push_addr), longint'({m_pline, 5'b0}));
      chk(why, "co_urgent", longint'(co_urgent), longint'(m_urg));
      @(posedge clk); @(negedge clk);
      chk("R2", "retry pulse ended", longint'(snp_retry), 0);
      chk("R2", "upd pulse ended", longint'(upd_valid), 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] a_m, b_m, c_e;
      void'($urandom(32'h5EED_0042));
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
         m_tag[s][w] = 0; m_st[s][w] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "retry in reset", longint'(snp_retry), 0);
      chk("R10", "push_req in reset", longint'(push_req), 0);
      chk("R10", "co_urgent in reset", longint'(co_urgent), 0);
      chk("R10", "upd_valid in reset", longint'(upd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      snoop(0, mk_addr(1, 3, 0), 1, " R10 lines invalid after reset");

      a_m = mk_addr(5, 3, 7);
      b_m = mk_addr(6, 4, 3);
      c_e = mk_addr(4, 5, 9);
      fill(3, 1, 5, 2);
      snoop(1, a_m, 2, "");
      snoop(2, a_m, 2, "");
      snoop(3, a_m, 2, "");
      snoop(0, a_m, 0, " R8 filled line seen");
      snoop(0, a_m, 0, "");
      fill(4, 2, 6, 2);
      snoop(0, b_m, 2, "");
      set_co(1, a_m);
      snoop(0, a_m, 1, " push beats cast-out");
      finish_push();
      snoop(0, a_m, 0, " cast-out after push");
      set_co(0, '0);
      snoop(0, a_m, 0, "");
      snoop(0, a_m, 1, "");
      snoop(0, a_m, 0, "");
      snoop(0, b_m, 2, "");
      finish_push();
      fill(5, 0, 4, 1);
      set_co(1, c_e);
      snoop(0, c_e, 1, "");
      snoop(0, c_e, 3, "");
      set_co(0, '0);
      snoop(0, c_e, 3, "");

      for (int i = 0; i < 600; i++) begin
         int op = int'($urandom_range(0, 99));
         if (op < 20) begin
            int w = int'($urandom_range(0, 3));
            fill(int'($urandom_range(0, 3)), w, w + 4 * int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 2)));
         end else if (op < 30) begin
            if (m_busy) finish_push();
         end else if (op < 36) begin
            set_co($urandom_range(0, 1) == 1,
                   mk_addr(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), 0));
         end else begin
            int md = ($urandom_range(0, 9) < 8) ? 0 : int'($urandom_range(1, 3));
            snoop(md, mk_addr(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                              int'($urandom_range(0, 31))),
                  int'($urandom_range(0, 3)), "");
         end
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule